// File: doc/BRIEF.md
# Mode-Dependent Effective Address Former

This block turns a computed reference address into the final word address that goes to memory. The way it forms that address depends on three processor status bits: master or slave operation, page mapping on or off, and real-extended addressing on or off. It also depends on what is being fetched (an instruction, an indirect word or an indexed operand) and, for the status-exchange instruction, on an addressing-type bit and on whether the instruction runs as the direct result of a trap or interrupt.

Depending on these inputs, the address is cut down to 17 bits, passed through at its full 20 bits, or translated through a loadable table of 256 page entries. Each page is 512 words, and the table maps a 17-bit virtual space onto a 1M-word real space. Alongside the address, the block marks references that need access protection. It also flags opcodes that are not allowed when executed as a trap or interrupt instruction. Each request is answered one clock later by a `done` strobe that carries the registered result.

Top module: `eaf_addr_former`

## Requirements
- R1: With `mode_map`=0 and `mode_ext`=0, the result is `{3'b000, ref_addr[16:0]}` for every access kind, whatever the value of `mode_slave`.
- R2: With `mode_map`=0 and `mode_ext`=1, the address width depends on `acc_kind`. An instruction fetch (`acc_kind`=0) or an indirect word (1) gives `{3'b000, ref_addr[16:0]}`. An indexed or indirect-result operand (2 or 3) gives all 20 bits of `ref_addr` untouched.
- R3: With `mode_map`=1, the page table is indexed by `ref_addr[16:9]`, and the result is `{entry, ref_addr[8:0]}`, where the entry is the stored 11-bit real page number. `ref_addr[19:17]` has no effect.
- R4: All page table entries reset to 0. When `map_we` is 1, `map_data` is written to entry `map_idx` at the clock edge. A request in that same cycle still sees the old entry.
- R5: `prot_chk` is 1 alongside `done` when `mode_slave`=0, `mode_map`=1 and `mode_ext`=1. It is 0 otherwise.
- R6: An instruction counts as a trap or interrupt instruction only when `vec_loc`=1 and `vec_direct`=1 in the same request. In every other case `illegal_op` is 0.
- R7: `op_class` encodes the opcode as 0 status-exchange, 1 push-status, 2 modify-word, 3 modify-halfword, 4 modify-byte, and 5 to 7 any other opcode. For an interrupt instruction (`vec_trap`=0), classes 0 to 4 are legal. For a trap instruction (`vec_trap`=1), only classes 0 and 1 are legal. An illegal class sets `illegal_op` alongside `done`.
- R8: For status-exchange (`op_class`=0) with `at_bit`=0, the result is all 20 bits of `ref_addr`, untranslated, in every mode, access kind and context.
- R9: For status-exchange with `at_bit`=1, the result is also all 20 bits of `ref_addr` when the instruction is a trap or interrupt instruction and the mode is not real-extended. Real-extended means `mode_map`=0 and `mode_ext`=1.
- R10: For status-exchange with `at_bit`=1 outside the R9 conditions, the address is formed exactly as R1 to R3 describe.
- R11: When `req_valid` is 1 at an edge, `done` is 1 for the following cycle, with `phys_addr`, `prot_chk` and `illegal_op` valid in that cycle. After reset, and in cycles with no request, `done`, `prot_chk` and `illegal_op` are 0. After reset `phys_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| mode_slave | input | 1 | 1 = slave mode, 0 = master |
| mode_map | input | 1 | Page mapping enable |
| mode_ext | input | 1 | Real-extended enable |
| acc_kind | input | 2 | 0 fetch, 1 indirect word, 2/3 indexed operand |
| ref_addr | input | 20 | Computed reference address |
| op_class | input | 3 | Opcode class (see R7) |
| at_bit | input | 1 | Addressing-type bit of status-exchange |
| vec_loc | input | 1 | Instruction sits in a trap/interrupt location |
| vec_direct | input | 1 | Executed as direct result of the event |
| vec_trap | input | 1 | 1 = trap event, 0 = interrupt event |
| map_we | input | 1 | Page table write enable |
| map_idx | input | 8 | Page table write index |
| map_data | input | 11 | Real page number to write |
| done | output | 1 | Result valid strobe |
| phys_addr | output | 20 | Final real word address |
| prot_chk | output | 1 | Access protection required |
| illegal_op | output | 1 | Illegal trap/interrupt instruction |

## Verification
A page table write and a translated request can happen in the same cycle. The bench provokes this by driving `map_we` together with a mapped request to the very page being rewritten. It expects that request to carry the old real page number, and the next request to the same page to carry the new one. The legality check and the status-exchange override also fall on the same request. The bench therefore combines illegal opcodes, trap and interrupt context and `at_bit` across mapped and real-extended modes, and compares address and flags together.

// File: rtl/eaf_pkg.sv
// Package: shared codes for the effective address former.
// Assumes opcode decode outside this block reduces the opcode to op_class.
package eaf_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_INDWORD = 2'd1,
        ACC_INDEXED = 2'd2,
        ACC_INDRES  = 2'd3
    } acc_kind_e;

    localparam logic [2:0] OPC_XCHG  = 3'd0;
    localparam logic [2:0] OPC_PUSH  = 3'd1;
    localparam logic [2:0] OPC_MODW  = 3'd2;
    localparam logic [2:0] OPC_MODH  = 3'd3;
    localparam logic [2:0] OPC_MODB  = 3'd4;
endpackage

// File: rtl/eaf_map_table.sv
// Module: page map storage.
// Holds one real page number per virtual page. It is written at the clock
// edge and read combinationally. A same-cycle reader sees the old entry.
// Assumes DEPTH = 2**IDX_W is small enough to hold in flops.
module eaf_map_table #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 11,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] entries [DEPTH];

    // Purpose: clear all entries on reset, else perform the load write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
        end else if (wr_en) begin
            entries[wr_idx] <= wr_data;
        end
    end

    // Purpose: combinational lookup of the requested page.
    assign rd_data = entries[rd_idx];

    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entries[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/eaf_ctx_decode.sv
// Module: mode and context classifier.
// Decides whether the status-exchange override applies, whether the mode
// calls for protection, and whether a trap/interrupt opcode is illegal.
// Assumes the inputs belong to one request. Purely combinational.
module eaf_ctx_decode
    import eaf_pkg::*;
(
    input  logic       mode_slave,
    input  logic       mode_map,
    input  logic       mode_ext,
    input  logic [2:0] op_class,
    input  logic       at_bit,
    input  logic       vec_loc,
    input  logic       vec_direct,
    input  logic       vec_trap,
    output logic       raw_sel,
    output logic       prot_need,
    output logic       op_illegal
);
    logic vec_instr;
    logic real_ext;
    logic legal_trap;
    logic legal_intr;

    // Purpose: an event instruction needs both location and direct execution.
    assign vec_instr = vec_loc & vec_direct;
    assign real_ext  = mode_ext & ~mode_map;

    // Purpose: opcode legality per event kind.
    always_comb begin
        legal_trap = (op_class == OPC_XCHG) || (op_class == OPC_PUSH);
        legal_intr = legal_trap || (op_class == OPC_MODW) ||
                     (op_class == OPC_MODH) || (op_class == OPC_MODB);
    end

    // Purpose: illegal flag only for genuine event instructions.
    assign op_illegal = vec_instr & (vec_trap ? ~legal_trap : ~legal_intr);

    // Purpose: status-exchange takes the untranslated 20-bit address.
    assign raw_sel = (op_class == OPC_XCHG) &&
                     (~at_bit || (vec_instr && ~real_ext));

    // Purpose: master-protected mode asks for protection on every reference.
    assign prot_need = ~mode_slave & mode_map & mode_ext;
endmodule

// File: rtl/eaf_addr_form.sv
// Module: address former.
// Picks between the full address, the 17-bit truncated address and the
// mapped address. Assumes rpn is the table entry for the vpn output.
// Purely combinational.
module eaf_addr_form
    import eaf_pkg::*;
#(
    parameter int VA_W   = 17,
    parameter int RA_W   = 20,
    parameter int PAGE_W = 9,
    localparam int VPN_W = VA_W - PAGE_W,
    localparam int RPN_W = RA_W - PAGE_W
) (
    input  logic [RA_W-1:0]  ref_addr,
    input  logic [1:0]       acc_kind,
    input  logic             mode_map,
    input  logic             mode_ext,
    input  logic             raw_sel,
    input  logic [RPN_W-1:0] rpn,
    output logic [VPN_W-1:0] vpn,
    output logic [RA_W-1:0]  addr
);
    logic [RA_W-1:0] narrow_addr;
    logic [RA_W-1:0] mapped_addr;
    logic            wide_kind;

    // Purpose: split the virtual address and build the candidate addresses.
    assign vpn         = ref_addr[VA_W-1:PAGE_W];
    assign narrow_addr = {{(RA_W-VA_W){1'b0}}, ref_addr[VA_W-1:0]};
    assign mapped_addr = {rpn, ref_addr[PAGE_W-1:0]};
    assign wide_kind   = (acc_kind == ACC_INDEXED) || (acc_kind == ACC_INDRES);

    // Purpose: priority select of the final address.
    always_comb begin
        if (raw_sel)                    addr = ref_addr;
        else if (mode_map)              addr = mapped_addr;
        else if (mode_ext && wide_kind) addr = ref_addr;
        else                            addr = narrow_addr;
    end
endmodule

// File: rtl/eaf_addr_former.sv
// Module: top of the effective address former.
// Registers the formed address and flags one cycle after a request.
// Assumes the map load port and requests come from the same clock domain.
module eaf_addr_former #(
    parameter int VA_W   = 17,
    parameter int RA_W   = 20,
    parameter int PAGE_W = 9,
    localparam int VPN_W = VA_W - PAGE_W,
    localparam int RPN_W = RA_W - PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             mode_slave,
    input  logic             mode_map,
    input  logic             mode_ext,
    input  logic [1:0]       acc_kind,
    input  logic [RA_W-1:0]  ref_addr,
    input  logic [2:0]       op_class,
    input  logic             at_bit,
    input  logic             vec_loc,
    input  logic             vec_direct,
    input  logic             vec_trap,
    input  logic             map_we,
    input  logic [VPN_W-1:0] map_idx,
    input  logic [RPN_W-1:0] map_data,
    output logic             done,
    output logic [RA_W-1:0]  phys_addr,
    output logic             prot_chk,
    output logic             illegal_op
);
    logic [VPN_W-1:0] vpn;
    logic [RPN_W-1:0] rpn;
    logic [RA_W-1:0]  addr_nxt;
    logic             raw_sel;
    logic             prot_need;
    logic             op_illegal;

    eaf_map_table #(.IDX_W(VPN_W), .DATA_W(RPN_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_idx(map_idx),
        .wr_data(map_data), .rd_idx(vpn), .rd_data(rpn)
    );

    eaf_ctx_decode u_ctx (
        .mode_slave(mode_slave), .mode_map(mode_map), .mode_ext(mode_ext),
        .op_class(op_class), .at_bit(at_bit), .vec_loc(vec_loc),
        .vec_direct(vec_direct), .vec_trap(vec_trap), .raw_sel(raw_sel),
        .prot_need(prot_need), .op_illegal(op_illegal)
    );

    eaf_addr_form #(.VA_W(VA_W), .RA_W(RA_W), .PAGE_W(PAGE_W)) u_form (
        .ref_addr(ref_addr), .acc_kind(acc_kind), .mode_map(mode_map),
        .mode_ext(mode_ext), .raw_sel(raw_sel), .rpn(rpn), .vpn(vpn),
        .addr(addr_nxt)
    );

    // Purpose: register the result and strobe done one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            phys_addr  <= '0;
            prot_chk   <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            done       <= req_valid;
            prot_chk   <= req_valid & prot_need;
            illegal_op <= req_valid & op_illegal;
            if (req_valid) phys_addr <= addr_nxt;
        end
    end

    a_r11_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid));
    a_r1_narrow_real: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(!mode_map && !mode_ext && !raw_sel)
        |-> phys_addr[RA_W-1:VA_W] == '0);
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(mode_map && !raw_sel)
        |-> phys_addr[PAGE_W-1:0] == $past(ref_addr[PAGE_W-1:0]));
    a_r8_raw_untranslated: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(raw_sel) |-> phys_addr == $past(ref_addr));
    a_r6_illegal_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $past(vec_loc && vec_direct));
    a_r5_prot_mode: assert property (@(posedge clk) disable iff (!rst_n)
        prot_chk |-> done && $past(!mode_slave && mode_map && mode_ext));
endmodule

// File: tb/eaf_addr_former_tb.sv
module eaf_addr_former_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, mode_slave = 0, mode_map = 0, mode_ext = 0;
    logic [1:0]  acc_kind = 0;
    logic [19:0] ref_addr = 0;
    logic [2:0]  op_class = 0;
    logic        at_bit = 0, vec_loc = 0, vec_direct = 0, vec_trap = 0;
    logic        map_we = 0;
    logic [7:0]  map_idx = 0;
    logic [10:0] map_data = 0;
    logic        done, prot_chk, illegal_op;
    logic [19:0] phys_addr;

    typedef struct {
        logic [19:0] addr;
        logic        prot;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [10:0] shadow [256];
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    eaf_addr_former u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .mode_slave(mode_slave), .mode_map(mode_map), .mode_ext(mode_ext),
        .acc_kind(acc_kind), .ref_addr(ref_addr), .op_class(op_class),
        .at_bit(at_bit), .vec_loc(vec_loc), .vec_direct(vec_direct),
        .vec_trap(vec_trap), .map_we(map_we), .map_idx(map_idx),
        .map_data(map_data), .done(done), .phys_addr(phys_addr),
        .prot_chk(prot_chk), .illegal_op(illegal_op)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Driver: present one request and push its expected result.
    task automatic issue(string tag, bit ms, bit mm, bit ma, logic [1:0] acc,
                         logic [19:0] ra, logic [2:0] op, bit at,
                         bit loc, bit dir, bit trp);
        exp_t e;
        bit   ev, raw;
        ev  = loc && dir;
        raw = (op == 3'd0) && (!at || (ev && !(ma && !mm)));
        if (raw)                       e.addr = ra;
        else if (mm)                   e.addr = {shadow[ra[16:9]], ra[8:0]};
        else if (ma && acc >= 2'd2)    e.addr = ra;
        else                           e.addr = {3'b000, ra[16:0]};
        e.prot = !ms && mm && ma;
        e.ill  = ev && (trp ? (op > 3'd1) : (op > 3'd4));
        e.tag  = tag;
        sb.push_back(e);
        req_valid = 1; mode_slave = ms; mode_map = mm; mode_ext = ma;
        acc_kind = acc; ref_addr = ra; op_class = op; at_bit = at;
        vec_loc = loc; vec_direct = dir; vec_trap = trp;
        @(negedge clk);
        req_valid = 0; map_we = 0;
    endtask

    task automatic load(logic [7:0] idx, logic [10:0] data);
        map_we = 1; map_idx = idx; map_data = data;
        @(negedge clk);
        map_we = 0;
        shadow[idx] = data;
    endtask

    task automatic idle(int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare each result when done is seen.
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R11 spurious done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (phys_addr !== e.addr || prot_chk !== e.prot || illegal_op !== e.ill) begin
                    errors++;
                    $display("FAIL %s actual addr=%h prot=%b ill=%b expected addr=%h prot=%b ill=%b",
                             e.tag, phys_addr, prot_chk, illegal_op, e.addr, e.prot, e.ill);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (done !== 0 || phys_addr !== 0 || prot_chk !== 0 || illegal_op !== 0) begin
            errors++;
            $display("FAIL R11 reset actual done=%b addr=%h prot=%b ill=%b expected 0 0 0 0",
                     done, phys_addr, prot_chk, illegal_op);
        end
        // R4: reset entries are zero
        issue("R4 reset entry", 0, 1, 0, 0, 20'h00A55, 3'd5, 0, 0, 0, 0);
        load(8'h05, 11'h7FF);
        load(8'h12, 11'h003);
        load(8'hFF, 11'h400);
        // R1 master and slave, all kinds
        issue("R1 master fetch", 0, 0, 0, 0, 20'hABCDE, 3'd5, 0, 0, 0, 0);
        issue("R1 slave indexed", 1, 0, 0, 2, 20'hFFFFF, 3'd5, 0, 0, 0, 0);
        // R2 real-extended
        issue("R2 fetch narrow", 0, 0, 1, 0, 20'hE1234, 3'd5, 0, 0, 0, 0);
        issue("R2 indword narrow", 1, 0, 1, 1, 20'h9FFFF, 3'd5, 0, 0, 0, 0);
        issue("R2 indexed wide", 0, 0, 1, 2, 20'hE1234, 3'd5, 0, 0, 0, 0);
        issue("R2 indres wide", 1, 0, 1, 3, 20'h80001, 3'd5, 0, 0, 0, 0);
        // R3 mapped, upper bits ignored
        issue("R3 map page05", 0, 1, 0, 0, 20'hE0A3C, 3'd5, 0, 0, 0, 0);
        issue("R3 map pageFF", 1, 1, 1, 2, 20'h1FFFF, 3'd5, 0, 0, 0, 0);
        issue("R3 map page12", 0, 1, 0, 1, 20'h02401, 3'd5, 0, 0, 0, 0);
        // R5 protection
        issue("R5 master protected", 0, 1, 1, 2, 20'h0A000, 3'd5, 0, 0, 0, 0);
        issue("R5 master mapped only", 0, 1, 0, 2, 20'h0A000, 3'd5, 0, 0, 0, 0);
        // R8 override at=0
        issue("R8 at0 mapped", 0, 1, 0, 0, 20'hF0A3C, 3'd0, 0, 0, 0, 0);
        issue("R8 at0 realext indword", 1, 0, 1, 1, 20'hC1234, 3'd0, 0, 1, 1, 1);
        // R9 / R10
        issue("R9 at1 trap mapped", 0, 1, 0, 0, 20'hB0A3C, 3'd0, 1, 1, 1, 1);
        issue("R9 at1 intr unmapped", 0, 0, 0, 0, 20'hB0A3C, 3'd0, 1, 1, 1, 0);
        issue("R10 at1 realext event", 0, 0, 1, 0, 20'hB0A3C, 3'd0, 1, 1, 1, 1);
        issue("R10 at1 branch reached", 0, 1, 0, 0, 20'hB0A3C, 3'd0, 1, 1, 0, 1);
        issue("R10 at1 no location", 0, 1, 1, 0, 20'hB0A3C, 3'd0, 1, 0, 1, 0);
        // R6 / R7 legality
        issue("R7 trap modw illegal", 0, 0, 0, 0, 20'h00100, 3'd2, 0, 1, 1, 1);
        issue("R7 intr modb legal", 0, 0, 0, 0, 20'h00100, 3'd4, 0, 1, 1, 0);
        issue("R7 intr other illegal", 0, 1, 1, 0, 20'h00100, 3'd5, 0, 1, 1, 0);
        issue("R7 trap push legal", 0, 0, 0, 0, 20'h00100, 3'd1, 0, 1, 1, 1);
        issue("R6 branch no flag", 0, 0, 0, 0, 20'h00100, 3'd7, 0, 1, 0, 1);
        issue("R6 direct not location", 0, 0, 0, 0, 20'h00100, 3'd6, 0, 0, 1, 0);
        // R4 same-cycle write and read of one page
        map_we = 1; map_idx = 8'h05; map_data = 11'h155;
        issue("R4 same cycle old entry", 0, 1, 0, 0, 20'h00A10, 3'd5, 0, 0, 0, 0);
        shadow[8'h05] = 11'h155;
        issue("R4 new entry visible", 0, 1, 0, 0, 20'h00A10, 3'd5, 0, 0, 0, 0);
        idle(3);
        checks++;
        if (sb.size() != 0 || done !== 0 || prot_chk !== 0 || illegal_op !== 0) begin
            errors++;
            $display("FAIL R11 idle actual pending=%0d done=%b expected pending=0 done=0",
                     sb.size(), done);
        end
        summary();
        $finish;
    end
endmodule